// File: doc/BRIEF.md
# Two-Stage Locked Watchdog Timer

A memory-mapped watchdog with a plain 32-bit register bus (byte address, write strobe, write data, registered read data). When software enables it, a first stage counts a programmable power-of-two number of clocks and then flags an interrupt. A second stage starts at once and counts its own power-of-two period. If nothing restarts the timer before that second stage ends, the block drives a system reset pulse. After a reset-stage expiry the timer goes back to the first stage and starts counting again.

The configuration and restart registers are guarded. A key value written to the arm register opens exactly one later write. A restart also needs its own key value in the data word. A status flag latches the first-stage expiry, and software clears it by writing a one. A clock-source bit is only stored, and it is driven out on a pin for logic outside the block. A parameter builds a narrow variant with a 16-bit counter. That variant limits the first-stage code to the lower half of the table.

Top module: `wdt_two_stage`

## Requirements
- R1: After synchronous reset, the configuration and status read as 0, the arm flag is clear, and `irq_o`, `sys_rst_o` and `clk_sel_o` are low.
- R2: A write of 0x5AA5 to the arm register (offset 0x18) arms one write. The arm flag reads back in bit 0 of 0x18. The next bus write to any offset uses up the arm, and any other write to 0x18 disarms it. Writes to 0x10 or 0x14 made while disarmed change nothing.
- R3: An armed write of 0xCAFE to offset 0x14 clears the count and returns the timer to the first stage. An armed write of any other value to 0x14 has no effect on the timing.
- R4: Configuration (offset 0x10) holds the following fields: bit 0 run, bit 1 clock select (driven on `clk_sel_o`), bit 2 interrupt enable, bit 3 reset enable, bits [7:4] first-stage code, bits [10:8] second-stage code. Bits [10:0] read back as written.
- R5: The first-stage period is 2^N clocks. Codes 0..15 give N = 6, 8, 10, 11, 12, 13, 14, 15, 17, 19, 21, 23, 25, 27, 29, 31. When the period ends, status bit 0 (offset 0x1C) is set, 2^N cycles after the accepted configuration write or restart.
- R6: The second stage starts when the first one expires and lasts 2^(7+code) clocks, with codes 0..7.
- R7: Writing 1 to status bit 0 clears it, and this needs no arm. Writing 0 leaves it unchanged. A same-cycle expiry takes priority over the clear.
- R8: `irq_o` is high exactly when status bit 0 and the interrupt enable are both set.
- R9: When the second stage expires with reset enable set, `sys_rst_o` goes high for RST_HOLD cycles. With reset enable clear, the expiry produces no pulse.
- R10: When CNT_W is 16, a first-stage code above 7 is stored and read back as 7.
- R11: Offset 0x00 reads the ID_VAL parameter. Offset 0x14 and all undefined offsets read 0. Read data appears one cycle after the address.
- R12: An armed write of 0 to the configuration stops the timer. No expiry happens while the run bit is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq_o | output | 1 | First-stage interrupt |
| sys_rst_o | output | 1 | System reset pulse |
| clk_sel_o | output | 1 | Stored clock-source select bit |

## Verification
The hardest case to reach from the ports is the second-stage expiry at its exact cycle. It can only follow a full first-stage period, and the run must never be disturbed by a restart, a reconfiguration or a stray write that uses up the arm. The bench uses the shortest codes and measures the cycle distances between the accepted write, the interrupt and the reset pulse. A longer code pair is then used to confirm that the table is not linear. A behavioural model, stepped every clock, covers the cases in between. These include wrong-key restarts, disarming writes and stopping the timer in the middle of a period.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  localparam logic [7:0]  OFF_ID    = 8'h00;
  localparam logic [7:0]  OFF_CFG   = 8'h10;
  localparam logic [7:0]  OFF_KICK  = 8'h14;
  localparam logic [7:0]  OFF_ARM   = 8'h18;
  localparam logic [7:0]  OFF_STAT  = 8'h1C;
  localparam logic [31:0] ARM_KEY   = 32'h0000_5AA5;
  localparam logic [31:0] KICK_KEY  = 32'h0000_CAFE;

  typedef struct packed {
    logic [2:0] rcode;
    logic [3:0] icode;
    logic       rst_en;
    logic       int_en;
    logic       clk_sel;
    logic       run;
  } wdt_cfg_t;

  // first-stage exponent: 6,8 then +1 up to 15, then +2 up to 31
  function automatic logic [4:0] int_exp(input logic [3:0] c);
    logic [4:0] cc;
    cc = {1'b0, c};
    if (c < 4'd2)      return 5'd6 + (cc << 1);
    else if (c < 4'd8) return cc + 5'd8;
    else               return (cc << 1) + 5'd1;
  endfunction

  function automatic logic [4:0] rst_exp(input logic [2:0] c);
    return 5'd7 + {2'b00, c};
  endfunction
endpackage

// File: rtl/wdt_stage_counter.sv
`timescale 1ns/1ps
module wdt_stage_counter #(
  parameter int CNT_W = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       reload,
  input  logic [3:0] icode,
  input  logic [2:0] rcode,
  output logic       int_fire,
  output logic       rst_fire
);
  import wdt_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic             in_rst_q;
  logic [CNT_W-1:0] imask, rmask;

  always_comb begin
    imask = {CNT_W{1'b1}} >> (CNT_W - int'(int_exp(icode)));
    rmask = {CNT_W{1'b1}} >> (CNT_W - int'(rst_exp(rcode)));
  end

  assign int_fire = run && !reload && !in_rst_q && (cnt_q == imask);
  assign rst_fire = run && !reload &&  in_rst_q && (cnt_q == rmask);

  always_ff @(posedge clk) begin
    if (rst || reload || !run) begin
      cnt_q    <= '0;
      in_rst_q <= 1'b0;
    end else if (int_fire) begin
      cnt_q    <= '0;
      in_rst_q <= 1'b1;
    end else if (rst_fire) begin
      cnt_q    <= '0;
      in_rst_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_regs.sv
`timescale 1ns/1ps
module wdt_regs #(
  parameter int          ADDR_W = 8,
  parameter int          CNT_W  = 32,
  parameter logic [31:0] ID_VAL = 32'h0057_D7C1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 we,
  input  logic [31:0]          wdata,
  input  logic                 int_fire,
  output wdt_pkg::wdt_cfg_t    cfg_o,
  output logic                 unlock_o,
  output logic                 status_o,
  output logic                 reload_o,
  output logic [31:0]          rdata_o
);
  import wdt_pkg::*;

  localparam bit NARROW = (CNT_W < 32);

  wdt_cfg_t cfg_q, cfg_nx;
  logic     unlock_q, status_q;
  logic     hit_cfg, hit_kick, hit_arm, hit_stat, cfg_acc, kick_acc;

  assign hit_cfg  = we && (addr == ADDR_W'(OFF_CFG));
  assign hit_kick = we && (addr == ADDR_W'(OFF_KICK));
  assign hit_arm  = we && (addr == ADDR_W'(OFF_ARM));
  assign hit_stat = we && (addr == ADDR_W'(OFF_STAT));
  assign cfg_acc  = hit_cfg && unlock_q;
  assign kick_acc = hit_kick && unlock_q && (wdata == KICK_KEY);
  assign reload_o = cfg_acc || kick_acc;

  generate
    if (NARROW) begin : g_clamp
      always_comb begin
        cfg_nx = wdt_cfg_t'(wdata[10:0]);
        if (cfg_nx.icode > 4'd7) cfg_nx.icode = 4'd7;
      end
    end else begin : g_full
      always_comb cfg_nx = wdt_cfg_t'(wdata[10:0]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      unlock_q <= 1'b0;
      status_q <= 1'b0;
      rdata_o  <= '0;
    end else begin
      if (we)       unlock_q <= hit_arm && (wdata == ARM_KEY);
      if (cfg_acc)  cfg_q    <= cfg_nx;
      if (int_fire)                  status_q <= 1'b1;
      else if (hit_stat && wdata[0]) status_q <= 1'b0;
      case (addr)
        ADDR_W'(OFF_ID):   rdata_o <= ID_VAL;
        ADDR_W'(OFF_CFG):  rdata_o <= {21'd0, cfg_q};
        ADDR_W'(OFF_ARM):  rdata_o <= {31'd0, unlock_q};
        ADDR_W'(OFF_STAT): rdata_o <= {31'd0, status_q};
        default:           rdata_o <= '0;
      endcase
    end
  end

  assign cfg_o    = cfg_q;
  assign unlock_o = unlock_q;
  assign status_o = status_q;
endmodule

// File: rtl/wdt_rst_pulse.sv
`timescale 1ns/1ps
module wdt_rst_pulse #(
  parameter int RST_HOLD = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic pulse_o
);
  localparam int HW = $clog2(RST_HOLD + 1);
  logic [HW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst)               left_q <= '0;
    else if (fire)         left_q <= HW'(RST_HOLD);
    else if (left_q != '0) left_q <= left_q - 1'b1;
  end

  assign pulse_o = (left_q != '0);
endmodule

// File: rtl/wdt_two_stage.sv
`timescale 1ns/1ps
module wdt_two_stage #(
  parameter int          ADDR_W   = 8,
  parameter int          CNT_W    = 32,
  parameter int          RST_HOLD = 4,
  parameter logic [31:0] ID_VAL   = 32'h0057_D7C1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o,
  output logic              sys_rst_o,
  output logic              clk_sel_o
);
  import wdt_pkg::*;

  wdt_cfg_t cfg_q;
  logic     unlock_q, status_q, reload, int_fire, rst_fire;

  wdt_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .ID_VAL(ID_VAL)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .int_fire(int_fire), .cfg_o(cfg_q), .unlock_o(unlock_q),
    .status_o(status_q), .reload_o(reload), .rdata_o(bus_rdata));

  wdt_stage_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(cfg_q.run), .reload(reload),
    .icode(cfg_q.icode), .rcode(cfg_q.rcode),
    .int_fire(int_fire), .rst_fire(rst_fire));

  wdt_rst_pulse #(.RST_HOLD(RST_HOLD)) u_pulse (
    .clk(clk), .rst(rst), .fire(rst_fire && cfg_q.rst_en),
    .pulse_o(sys_rst_o));

  assign irq_o     = status_q && cfg_q.int_en;
  assign clk_sel_o = cfg_q.clk_sel;
endmodule

// File: rtl/wdt_two_stage_chk.sv
`timescale 1ns/1ps
module wdt_two_stage_chk (
  input logic        clk,
  input logic        rst,
  input logic        unlock_q,
  input logic [10:0] cfg_bits,
  input logic        status_q,
  input logic        reload,
  input logic        int_fire,
  input logic        rst_fire,
  input logic        sys_rst_o
);
  AST_LOCKED_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(unlock_q) |-> $stable(cfg_bits)); // R2
  AST_RELOAD_NO_FIRE: assert property (@(posedge clk) disable iff (rst)
    $past(reload) |-> !(int_fire || rst_fire)); // R3
  AST_STATUS_FROM_EXPIRY: assert property (@(posedge clk) disable iff (rst)
    $rose(status_q) |-> $past(int_fire)); // R5
  AST_STAGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(int_fire && rst_fire)); // R6
  AST_PULSE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_o) |-> $past(cfg_bits[3])); // R9
  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !cfg_bits[0] |-> !(int_fire || rst_fire)); // R12
endmodule

bind wdt_two_stage wdt_two_stage_chk u_chk (
  .clk(clk), .rst(rst), .unlock_q(unlock_q), .cfg_bits(cfg_q),
  .status_q(status_q), .reload(reload), .int_fire(int_fire),
  .rst_fire(rst_fire), .sys_rst_o(sys_rst_o));

// File: tb/tb_wdt_two_stage.sv
`timescale 1ns/1ps
module tb_wdt_two_stage;
  localparam int          HOLD = 4;
  localparam logic [31:0] IDV  = 32'h0057_D7C1;

  logic        clk = 1'b0, rst = 1'b1, we = 1'b0;
  logic [7:0]  addr = 8'h04;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata16;
  logic        irq, srst, csel, irq16, srst16, csel16;
  int n_chk = 0, n_err = 0;
  longint cyc = 0;

  always #4 clk = ~clk;

  wdt_two_stage #(.RST_HOLD(HOLD), .ID_VAL(IDV)) dut (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdata), .irq_o(irq), .sys_rst_o(srst), .clk_sel_o(csel));

  wdt_two_stage #(.CNT_W(16), .RST_HOLD(HOLD), .ID_VAL(IDV)) dut16 (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdata16), .irq_o(irq16), .sys_rst_o(srst16), .clk_sel_o(csel16));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int     itab [16] = '{6, 8, 10, 11, 12, 13, 14, 15, 17, 19, 21, 23, 25, 27, 29, 31};
  int     m_cfg, m_unl, m_stat, m_stage, m_hold;
  longint m_cnt;
  logic [31:0] m_rd;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_cfg = 0; m_unl = 0; m_stat = 0; m_stage = 0; m_hold = 0; m_cnt = 0; m_rd = 0;
    end else begin
      logic [31:0] nrd;
      bit cacc, kacc, rl, run, ifire, rfire;
      longint ip, rp;
      case (addr)
        8'h00: nrd = IDV;
        8'h10: nrd = m_cfg;
        8'h18: nrd = m_unl;
        8'h1C: nrd = m_stat;
        default: nrd = 0;
      endcase
      cacc = we && addr == 8'h10 && m_unl != 0;
      kacc = we && addr == 8'h14 && m_unl != 0 && wdata == 32'hCAFE;
      rl   = cacc || kacc;
      run  = (m_cfg & 1) != 0;
      ip   = (longint'(1) << itab[(m_cfg >> 4) & 15]) - 1;
      rp   = (longint'(1) << (7 + ((m_cfg >> 8) & 7))) - 1;
      ifire = run && !rl && m_stage == 0 && m_cnt == ip;
      rfire = run && !rl && m_stage == 1 && m_cnt == rp;
      if (rl || !run) begin m_cnt = 0; m_stage = 0; end
      else if (ifire) begin m_cnt = 0; m_stage = 1; end
      else if (rfire) begin m_cnt = 0; m_stage = 0; end
      else m_cnt++;
      if (ifire) m_stat = 1;
      else if (we && addr == 8'h1C && wdata[0]) m_stat = 0;
      if (rfire && ((m_cfg >> 3) & 1) != 0) m_hold = HOLD;
      else if (m_hold > 0) m_hold--;
      if (we) m_unl = (addr == 8'h18 && wdata == 32'h5AA5) ? 1 : 0;
      if (cacc) m_cfg = wdata & 32'h7FF;
      m_rd = nrd;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R8 irq vs model", irq, (m_stat != 0) && (((m_cfg >> 2) & 1) != 0));
      chk("R9 sys_rst vs model", srst, m_hold != 0);
      chk("R4 clk_sel vs model", csel, ((m_cfg >> 1) & 1) != 0);
      chk("R11 rdata vs model", rdata, m_rd);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #1; addr = a; we = 1'b1; wdata = d;
    @(negedge clk); #1; we = 1'b0; addr = 8'h04; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic [31:0] d16);
    @(negedge clk); #1; addr = a; we = 1'b0;
    @(negedge clk); d = rdata; d16 = rdata16;
  endtask

  task automatic key_wr(input logic [7:0] a, input logic [31:0] d);
    wr(8'h18, 32'h5AA5);
    wr(a, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic halt_clear();
    key_wr(8'h10, 32'h0);
    wr(8'h1C, 32'h1);
  endtask

  // watchdog for a hung run
  initial begin
    #(8 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] v, v16;
    longint t0;
    bit seen;
    idle(5); #1; rst = 1'b0;
    // R1 reset state
    chk("R1 irq after reset", irq, 0);
    chk("R1 sys_rst after reset", srst, 0);
    chk("R1 clk_sel after reset", csel, 0);
    rd(8'h10, v, v16); chk("R1 cfg after reset", v, 0);
    rd(8'h1C, v, v16); chk("R1 status after reset", v, 0);
    rd(8'h18, v, v16); chk("R1 arm after reset", v, 0);
    // R11 read map
    rd(8'h00, v, v16); chk("R11 id", v, IDV);
    rd(8'h14, v, v16); chk("R11 kick reads 0", v, 0);
    rd(8'h04, v, v16); chk("R11 undefined 0x04", v, 0);
    rd(8'h20, v, v16); chk("R11 undefined 0x20", v, 0);
    // R2 arming
    wr(8'h10, 32'hF);
    rd(8'h10, v, v16); chk("R2 locked cfg write ignored", v, 0);
    wr(8'h18, 32'h5AA5);
    rd(8'h18, v, v16); chk("R2 arm flag set", v, 1);
    wr(8'h18, 32'h1234);
    rd(8'h18, v, v16); chk("R2 other arm value disarms", v, 0);
    wr(8'h18, 32'h5AA5); wr(8'h1C, 32'h0); wr(8'h10, 32'h3);
    rd(8'h10, v, v16); chk("R2 arm used by status write", v, 0);
    // R4 fields
    key_wr(8'h10, 32'h2);
    chk("R4 clk_sel pin", csel, 1);
    rd(8'h10, v, v16); chk("R4 cfg readback", v, 32'h2);
    key_wr(8'h10, 32'h7FA);
    rd(8'h10, v, v16); chk("R4 all fields readback", v, 32'h7FA);
    // R10 narrow clamp
    key_wr(8'h10, 32'hC0);
    rd(8'h10, v, v16);
    chk("R10 wide keeps code 12", v, 32'hC0);
    chk("R10 narrow clamps to 7", v16, 32'h70);
    // R5 R6 R9 shortest codes
    key_wr(8'h10, 32'hD);
    t0 = cyc; while (!irq && cyc - t0 < 100000) @(negedge clk);
    chk("R5 first stage code0 cycles", 32'(cyc - t0), 64);
    t0 = cyc; while (!srst && cyc - t0 < 100000) @(negedge clk);
    chk("R6 second stage code0 cycles", 32'(cyc - t0), 128);
    t0 = cyc; while (srst && cyc - t0 < 100) @(negedge clk);
    chk("R9 reset pulse width", 32'(cyc - t0), HOLD);
    halt_clear();
    // R7 status clear
    key_wr(8'h10, 32'h1);
    idle(80);
    halt_clear();
    wr(8'h1C, 32'h0);
    rd(8'h1C, v, v16); chk("R7 status after clear", v, 0);
    key_wr(8'h10, 32'h1);
    idle(80);
    key_wr(8'h10, 32'h0);
    wr(8'h1C, 32'h0);
    rd(8'h1C, v, v16); chk("R7 write 0 leaves status", v, 1);
    chk("R8 irq low without enable", irq, 0);
    wr(8'h1C, 32'h1);
    rd(8'h1C, v, v16); chk("R7 write 1 clears status", v, 0);
    // R3 wrong key then right key
    key_wr(8'h10, 32'h5);
    t0 = cyc;
    key_wr(8'h14, 32'h1111);
    while (!irq && cyc - t0 < 100000) @(negedge clk);
    chk("R3 wrong key leaves timing", 32'(cyc - t0), 64);
    halt_clear();
    key_wr(8'h10, 32'h5);
    idle(30);
    key_wr(8'h14, 32'hCAFE);
    t0 = cyc; while (!irq && cyc - t0 < 100000) @(negedge clk);
    chk("R3 restart reloads first stage", 32'(cyc - t0), 64);
    halt_clear();
    // R9 no pulse without reset enable
    key_wr(8'h10, 32'h5);
    seen = 0;
    for (int i = 0; i < 400; i++) begin @(negedge clk); if (srst) seen = 1; end
    chk("R9 no pulse when disabled", seen, 0);
    halt_clear();
    // R12 stopped timer stays quiet
    key_wr(8'h10, 32'hD);
    idle(20);
    key_wr(8'h10, 32'h0);
    seen = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (srst || irq) seen = 1; end
    chk("R12 stopped no activity", seen, 0);
    rd(8'h1C, v, v16); chk("R12 status stays clear", v, 0);
    // R5 R6 longer codes: first code 3 -> 2^11, second code 2 -> 2^9
    key_wr(8'h10, 32'h23D);
    t0 = cyc; while (!irq && cyc - t0 < 100000) @(negedge clk);
    chk("R5 first stage code3 cycles", 32'(cyc - t0), 2048);
    t0 = cyc; while (!srst && cyc - t0 < 100000) @(negedge clk);
    chk("R6 second stage code2 cycles", 32'(cyc - t0), 512);
    halt_clear();
    idle(4);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule